// File: doc/BRIEF.md
# Serial GFC Field Output Port

This block presents the four-bit generic flow control (GFC) field of each accepted ATM cell as a serial bit stream, one bit per byte-rate clock. The receive path pulses a cell-written strobe with the GFC nibble, which is the upper nibble of the first header byte. After a fixed delay of six byte times the block raises a one-cycle start marker and drives the field's most significant bit on the serial output. The remaining three bits follow on the next three cycles.

A loss-of-cell-delineation flag keeps the serial output and the marker low. It also discards any field that is waiting for its delay or is partway through its shift. If a second strobe arrives before a waiting field has started, the newer field takes its place and the delay starts again. Between fields both outputs stay low. Every output is a register clocked by the byte-rate clock.

Top module: `gfc_serial_port`

## Requirements
- R1: The field is shifted out most significant bit first (bit 3, then 2, 1, 0) on four consecutive byte-clock cycles, beginning in the cycle the start marker is high.
- R2: The start marker is high for exactly one cycle per field, in the same cycle as the field's bit 3.
- R3: A strobe sampled with the loss flag low at clock edge E makes the marker and bit 3 appear in the cycle after edge E+6.
- R4: In the cycle after any clock edge at which the loss flag is sampled high, the serial output and the marker are both low.
- R5: If the loss flag is sampled high while a field is being shifted, the rest of that field is dropped and no marker is issued for it later, even after the flag drops.
- R6: If the loss flag is sampled high while a field is waiting out its delay, that field is cancelled and never appears.
- R7: A strobe sampled at an edge where the loss flag is also high is discarded.
- R8: A strobe that arrives while an earlier field is still waiting replaces that field's nibble, and the delay restarts from the new strobe.
- R9: When no field is active, both outputs are low. A strobe that arrives at the same edge where a waiting field becomes due lets that field start, and then begins its own delay, so both fields appear in turn.
- R10: While reset is asserted and after it is released, both outputs are low and no field is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Byte-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cell_wr_i | input | 1 | Strobe: a cell was written to the receive FIFO |
| gfc_i | input | GFC_W | GFC nibble of that cell, sampled with the strobe |
| lcd_i | input | 1 | Cell delineation lost |
| gfc_ser_o | output | 1 | Serial GFC bit |
| gfc_start_o | output | 1 | Marker for the first GFC bit |

## Verification
The bench sends every nibble value through the port and checks all eleven cycles after each strobe. A wrong bit order, an off-by-one delay or a marker that lasts more than one cycle would each show up at a known cycle. It raises the loss flag in the middle of a shift and during the wait. A design that only masked the output, instead of clearing its state, would let leftover bits or a late marker through once the flag drops. It also sends a second strobe during the wait and another at the exact edge the first field becomes due. A design that queued the first field or lost the second would produce two markers in the first case, or be missing one in the second.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  localparam int unsigned GFC_FIELD_W = 4;
  localparam int unsigned GFC_DELAY   = 6;
endpackage

// File: rtl/gfc_delay_timer.sv
module gfc_delay_timer #(
  parameter int unsigned DELAY = 6,
  parameter int unsigned W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         flush_i,
  input  logic [W-1:0] nib_i,
  output logic         fire_o,
  output logic [W-1:0] nib_o
);
  localparam int unsigned CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(DELAY - 1);

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     nib_q;

  assign fire_o = pend_q && (cnt_q == '0);
  assign nib_o  = nib_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      nib_q  <= '0;
    end else if (flush_i) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      // newer strobe replaces any waiting field
      pend_q <= 1'b1;
      cnt_q  <= CNT_INIT;
      nib_q  <= nib_i;
    end else if (fire_o) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_delay_countdown_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !load_i && !flush_i && cnt_q != '0) |=> (pend_q && cnt_q == $past(cnt_q) - 1'b1));

  p_flush_cancels_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !fire_o);
endmodule

// File: rtl/gfc_field_shifter.sv
module gfc_field_shifter #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         load_i,
  input  logic [W-1:0] field_i,
  output logic         ser_o,
  output logic         start_o
);
  localparam int unsigned LEFT_W = $clog2(W + 1);
  localparam logic [LEFT_W-1:0] LEFT_FULL = LEFT_W'(W);

  logic [W-1:0]      sh_q;
  logic [LEFT_W-1:0] left_q;
  logic              first_q;

  assign ser_o   = (left_q != '0) && sh_q[W-1];
  assign start_o = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else if (flush_i) begin
      sh_q    <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else if (load_i) begin
      sh_q    <= field_i;
      left_q  <= LEFT_FULL;
      first_q <= 1'b1;
    end else if (left_q != '0) begin
      sh_q    <= sh_q << 1;
      left_q  <= left_q - 1'b1;
      first_q <= 1'b0;
    end else begin
      first_q <= 1'b0;
    end
  end

  p_start_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !load_i) |=> !start_o);

  p_shift_countdown_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q != '0 && !load_i && !flush_i) |=> (left_q == $past(left_q) - 1'b1));

  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q == '0 && !load_i) |=> (!ser_o && !start_o));
endmodule

// File: rtl/gfc_serial_port.sv
module gfc_serial_port #(
  parameter int unsigned GFC_W = gfc_pkg::GFC_FIELD_W,
  parameter int unsigned DELAY = gfc_pkg::GFC_DELAY
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cell_wr_i,
  input  logic [GFC_W-1:0] gfc_i,
  input  logic             lcd_i,
  output logic             gfc_ser_o,
  output logic             gfc_start_o
);
  logic             accept;
  logic             fire;
  logic [GFC_W-1:0] due_nib;

  assign accept = cell_wr_i && !lcd_i;

  gfc_delay_timer #(.DELAY(DELAY), .W(GFC_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .flush_i (lcd_i),
    .nib_i   (gfc_i),
    .fire_o  (fire),
    .nib_o   (due_nib)
  );

  gfc_field_shifter #(.W(GFC_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (lcd_i),
    .load_i  (fire),
    .field_i (due_nib),
    .ser_o   (gfc_ser_o),
    .start_o (gfc_start_o)
  );

  p_fire_starts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !lcd_i) |=> (gfc_start_o && gfc_ser_o == $past(due_nib[GFC_W-1])));

  p_lcd_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_i |=> (!gfc_ser_o && !gfc_start_o));

  p_wr_in_lcd_dropped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_wr_i && lcd_i) |=> !fire);
endmodule

// File: tb/gfc_serial_port_bench.sv
module gfc_serial_port_bench;
  localparam int PERIOD = 10;
  localparam int D = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [3:0] nib = '0;
  logic       lcd = 1'b0;
  logic       ser, start;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  gfc_serial_port u_gfc_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .cell_wr_i(wr), .gfc_i(nib),
    .lcd_i(lcd), .gfc_ser_o(ser), .gfc_start_o(start)
  );

  task automatic chk(input logic es, input logic ek, input string req);
    checks++;
    if (ser !== es || start !== ek) begin
      errors++;
      $display("FAIL %s t=%0t ser=%b start=%b expected ser=%b start=%b",
               req, $time, ser, start, es, ek);
    end
  endtask

  // apply inputs for one edge, then check outputs at the following falling edge
  task automatic step(input logic w, input logic [3:0] n, input logic l,
                      input logic es, input logic ek, input string req);
    wr = w; nib = n; lcd = l;
    @(negedge clk);
    chk(es, ek, req);
  endtask

  function automatic logic exp_bit(input logic [3:0] v, input int off);
    return (off >= 0 && off < 4) ? v[3-off] : 1'b0;
  endfunction

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(1'b0, 1'b0, "R10 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 4'h0, 0, 0, 0, "R10 after reset");

    // R1 R2 R3: all nibbles
    for (int v = 0; v < 16; v++) begin
      for (int i = 0; i <= D + 4; i++)
        step(i == 0, (i == 0) ? 4'(v) : 4'h0, 0, exp_bit(4'(v), i - D), i == D, "R1/R2/R3 sweep");
    end

    // R5: loss flag at edge D+1 (after bit 3 shown)
    for (int i = 0; i <= D + 8; i++) begin
      logic es, ek;
      es = (i == D) ? 1'b1 : 1'b0;
      ek = (i == D);
      step(i == 0, 4'hF, i == D + 1, es, ek, "R5 lcd mid-field");
    end
    // R4: lcd held several edges, no output
    for (int i = 0; i < 4; i++) step(0, 4'h0, 1, 0, 0, "R4 lcd held");

    // R6: loss flag during the wait
    for (int i = 0; i <= D + 6; i++)
      step(i == 0, 4'hF, i == 3, 0, 0, "R6 lcd while waiting");

    // R7: strobe with lcd high
    for (int i = 0; i <= D + 6; i++)
      step(i == 0, 4'hF, i == 0, 0, 0, "R7 strobe during lcd");

    // R8: second strobe at step 3 replaces first; field B at step 3+D
    for (int i = 0; i <= D + 8; i++) begin
      logic w;
      logic [3:0] n;
      w = (i == 0) || (i == 3);
      n = (i == 0) ? 4'hF : 4'hA;
      step(w, n, 0, exp_bit(4'hA, i - 3 - D), i == 3 + D, "R8 replace");
    end

    // R9: strobe at the due edge; both fields appear
    for (int i = 0; i <= 2*D + 5; i++) begin
      logic w;
      logic [3:0] n;
      logic es;
      w = (i == 0) || (i == D);
      n = (i == 0) ? 4'h9 : 4'h6;
      es = (i < 2*D) ? exp_bit(4'h9, i - D) : exp_bit(4'h6, i - 2*D);
      step(w, n, 0, es, (i == D) || (i == 2*D), "R9 back-to-back");
    end

    // R10: async reset mid-wait clears pending field
    step(1, 4'hF, 0, 0, 0, "R10 load before reset");
    rst_n = 1'b0;
    @(negedge clk);
    chk(0, 0, "R10 reset asserted");
    rst_n = 1'b1;
    for (int i = 0; i <= D + 4; i++) step(0, 4'h0, 0, 0, 0, "R10 nothing after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule